// File: doc/BRIEF.md
# Ethernet Transmit Fault Handler

This block sits beside the transmit path of an Ethernet MAC and turns line events into per-frame fault status and buffer-sequencing commands. It follows each frame from its start to its end. It watches for a transmit FIFO running dry, for the retry budget running out, for a collision that arrives past the slot time, and for the carrier dropping while the frame is on the wire. When the frame has left the MAC it can also time the transceiver's self-test collision.

Each fault class is recovered in its own way. An underrun first drives a fixed run of bits that make the frame's CRC wrong at the receiver, then requests a flush of the frame's remaining buffers. A retry-limit or late-collision abort requests the flush at once. Carrier loss is only noted and the frame runs to its end. A missing self-test collision is detected in a window after the frame. Once the frame's last buffer is closed, a 5-bit status word is offered to the descriptor writer through a valid/ready handshake, and a one-cycle strobe then tells the fetch logic to move on to the next frame.

Serialisation, CRC generation, backoff timing and descriptor memory live outside this block.

Top module: `tx_fault_ctrl`

## Requirements
- R1: After `fifo_underrun` is sampled high during a frame, `force_bad_crc` is high for exactly JAM_BITS/BITS_PER_CLK cycles (8 by default), starting in the next cycle. `flush_req` rises in the cycle after the last of those cycles, and the two outputs are never high together.
- R2: `flush_req` stays high until `buf_done` and `buf_last` are sampled high together. `st_valid` rises in the next cycle. The status word has underrun at bit 0, retry limit at bit 2 and late collision at bit 3.
- R3: When `retry_limit` is sampled high during a frame, `flush_req` rises in the next cycle with no corrupted-CRC phase, and status bit 2 is set.
- R4: A collision sampled at least SLOT_BITS/BITS_PER_CLK cycles (128 by default) after the frame's first cycle aborts the frame and sets status bit 3. An earlier collision neither aborts the frame nor raises `flush_req`.
- R5: Carrier loss in a half-duplex frame that sees no collision sets status bit 1 (carrier lost). The frame is not aborted and ends normally.
- R6: While `full_duplex` is high, bit 1 of the status word is never set, whatever `carrier_sense` does.
- R7: With `hb_chk_en` low, `st_valid` rises one cycle after the cycle in which `frm_end` is high. With `hb_chk_en` high, a collision within HB_WIN cycles (20 by default) after the frame clears the check and reports at once. Otherwise bit 4 is set and `st_valid` rises HB_WIN+1 cycles after the `frm_end` cycle.
- R8: `hb_irq` is a one-cycle pulse in the first cycle of `st_valid`. It fires only when bit 4 is set and `hb_irq_en` is high.
- R9: A frame that is aborted never gets a heartbeat window. Its status is offered in the cycle after its last buffer closes, even when `hb_chk_en` is high.
- R10: When several faults occur in one frame, the status word carries every one of their bits.
- R11: While `st_valid` is high and `st_ready` is low, `st_valid` and `tx_status` hold steady. `next_frame` pulses for exactly one cycle, in the cycle after the handshake completes.
- R12: After reset, `force_bad_crc`, `flush_req`, `st_valid`, `next_frame` and `hb_irq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | Pulse in the first cycle of a frame |
| frm_end | input | 1 | Pulse when the frame's final bits have been sent |
| fifo_underrun | input | 1 | Transmit FIFO ran empty mid-frame |
| carrier_sense | input | 1 | Carrier present on the medium |
| collision | input | 1 | Collision indication from the transceiver |
| retry_limit | input | 1 | Retransmission budget used up |
| buf_done | input | 1 | A buffer of the current frame has been closed |
| buf_last | input | 1 | The closed buffer is the frame's last one |
| full_duplex | input | 1 | Full-duplex operation |
| hb_chk_en | input | 1 | Enable the post-frame heartbeat check |
| hb_irq_en | input | 1 | Enable the heartbeat-error interrupt |
| force_bad_crc | output | 1 | Drive CRC-corrupting bits |
| flush_req | output | 1 | Flush and close the frame's remaining buffers |
| st_valid | output | 1 | Status word offered to the descriptor writer |
| st_ready | input | 1 | Descriptor writer accepts the status |
| tx_status | output | 5 | {heartbeat, late col, retry limit, carrier lost, underrun} |
| next_frame | output | 1 | Strobe to advance to the next frame |
| hb_irq | output | 1 | Heartbeat-error interrupt pulse |

## Verification
Each result has a fixed latency. The CRC-corrupting phase starts one cycle after the underrun is sampled and lasts 8 cycles. The status is offered one cycle after the end of the frame or after the last buffer closes. With the heartbeat check on, a missing collision delays the status by 21 cycles after the end-of-frame cycle. The advance strobe comes one cycle after the handshake. The bench drives inputs on the falling edge and samples just after it, so it counts falling edges from each stimulus and reads the outputs exactly where each result is due, including one cycle early to show the output has not yet moved. A scoreboard queue holds the expected status and interrupt for each frame, and a monitor compares them at every handshake.

// File: rtl/tx_fault_pkg.sv
package tx_fault_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SEND,
    S_JAM,
    S_FLUSH,
    S_HBWAIT,
    S_REPORT
  } txf_state_e;

  localparam int FLAG_W  = 5;
  localparam int F_UNDER = 0;
  localparam int F_CARR  = 1;
  localparam int F_RETRY = 2;
  localparam int F_LATE  = 3;
  localparam int F_HBEAT = 4;

endpackage

// File: rtl/txf_span_counter.sv
// Saturating cycle counter: 'last' marks count LIMIT-1, 'past' marks LIMIT reached.
module txf_span_counter #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic last,
  output logic past
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] TOP = W'(LIMIT);
  localparam logic [W-1:0] PEN = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (en && cnt != TOP) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign last = (cnt == PEN);
  assign past = (cnt == TOP);
endmodule

// File: rtl/txf_fault_flags.sv
// Per-frame fault accumulator; carrier loss is reported only without any collision.
module txf_fault_flags
  import tx_fault_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              set_under,
  input  logic              set_retry,
  input  logic              set_late,
  input  logic              set_hbeat,
  input  logic              carr_drop,
  input  logic              col_seen,
  output logic [FLAG_W-1:0] status
);
  logic under_q, retry_q, late_q, hbeat_q, carr_q, col_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      under_q <= 1'b0;
      retry_q <= 1'b0;
      late_q  <= 1'b0;
      hbeat_q <= 1'b0;
      carr_q  <= 1'b0;
      col_q   <= 1'b0;
    end else begin
      under_q <= under_q | set_under;
      retry_q <= retry_q | set_retry;
      late_q  <= late_q  | set_late;
      hbeat_q <= hbeat_q | set_hbeat;
      carr_q  <= carr_q  | carr_drop;
      col_q   <= col_q   | col_seen;
    end
  end

  always_comb begin
    status          = '0;
    status[F_UNDER] = under_q;
    status[F_CARR]  = carr_q & ~col_q;
    status[F_RETRY] = retry_q;
    status[F_LATE]  = late_q;
    status[F_HBEAT] = hbeat_q;
  end
endmodule

// File: rtl/tx_fault_ctrl.sv
module tx_fault_ctrl
  import tx_fault_pkg::*;
#(
  parameter int BITS_PER_CLK = 4,
  parameter int SLOT_BITS    = 512,
  parameter int JAM_BITS     = 32,
  parameter int HB_WIN       = 20
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        frm_start,
  input  logic        frm_end,
  input  logic        fifo_underrun,
  input  logic        carrier_sense,
  input  logic        collision,
  input  logic        retry_limit,
  input  logic        buf_done,
  input  logic        buf_last,
  input  logic        full_duplex,
  input  logic        hb_chk_en,
  input  logic        hb_irq_en,
  output logic        force_bad_crc,
  output logic        flush_req,
  output logic        st_valid,
  input  logic        st_ready,
  output logic [4:0]  tx_status,
  output logic        next_frame,
  output logic        hb_irq
);
  localparam int LATE_CYC = SLOT_BITS / BITS_PER_CLK;
  localparam int JAM_CYC  = JAM_BITS / BITS_PER_CLK;

  txf_state_e state, nxt;

  logic in_send, late_past, jam_last, hb_last;
  logic ev_under, ev_retry, ev_late, ev_abort, hb_miss;

  assign in_send  = (state == S_SEND);
  assign ev_under = in_send && fifo_underrun;
  assign ev_retry = in_send && retry_limit;
  assign ev_late  = in_send && collision && late_past;
  assign ev_abort = ev_under || ev_retry || ev_late;
  assign hb_miss  = (state == S_HBWAIT) && hb_last && !collision;

  // frame position since start, for the fixed late-collision threshold
  txf_span_counter #(.LIMIT(LATE_CYC)) u_slot (
    .clk (clk),
    .rst (rst),
    .clr (state == S_IDLE),
    .en  (in_send),
    .last(),
    .past(late_past)
  );

  // length of the CRC-corrupting phase
  txf_span_counter #(.LIMIT(JAM_CYC)) u_jam (
    .clk (clk),
    .rst (rst),
    .clr (state != S_JAM),
    .en  (state == S_JAM),
    .last(jam_last),
    .past()
  );

  // heartbeat window after the frame
  txf_span_counter #(.LIMIT(HB_WIN)) u_hb (
    .clk (clk),
    .rst (rst),
    .clr (state != S_HBWAIT),
    .en  (state == S_HBWAIT),
    .last(hb_last),
    .past()
  );

  txf_fault_flags u_flags (
    .clk      (clk),
    .rst      (rst),
    .clr      ((state == S_IDLE) && frm_start),
    .set_under(ev_under),
    .set_retry(ev_retry),
    .set_late (ev_late),
    .set_hbeat(hb_miss),
    .carr_drop(in_send && !carrier_sense && !full_duplex),
    .col_seen (in_send && collision),
    .status   (tx_status)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:   if (frm_start) nxt = S_SEND;
      S_SEND: begin
        if (ev_under)      nxt = S_JAM;
        else if (ev_abort) nxt = S_FLUSH;
        else if (frm_end)  nxt = hb_chk_en ? S_HBWAIT : S_REPORT;
      end
      S_JAM:    if (jam_last) nxt = S_FLUSH;
      S_FLUSH:  if (buf_done && buf_last) nxt = S_REPORT;
      S_HBWAIT: if (collision || hb_last) nxt = S_REPORT;
      S_REPORT: if (st_ready) nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      force_bad_crc <= 1'b0;
      flush_req     <= 1'b0;
      st_valid      <= 1'b0;
      next_frame    <= 1'b0;
      hb_irq        <= 1'b0;
    end else begin
      state         <= nxt;
      force_bad_crc <= (nxt == S_JAM);
      flush_req     <= (nxt == S_FLUSH);
      st_valid      <= (nxt == S_REPORT);
      next_frame    <= (state == S_REPORT) && st_ready;
      hb_irq        <= hb_miss && hb_irq_en;
    end
  end
endmodule

// File: rtl/tx_fault_ctrl_chk.sv
module tx_fault_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       hb_irq_en,
  input logic       force_bad_crc,
  input logic       flush_req,
  input logic       st_valid,
  input logic       st_ready,
  input logic [4:0] tx_status,
  input logic       next_frame,
  input logic       hb_irq
);
  // R1
  jam_flush_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(force_bad_crc && flush_req));

  // R1
  jam_then_flush_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(force_bad_crc) |-> flush_req);

  // R11
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !st_ready) |=> (st_valid && $stable(tx_status)));

  // R11
  advance_after_hs_chk: assert property (@(posedge clk) disable iff (rst)
    next_frame |-> $past(st_valid && st_ready));

  // R8
  irq_qualified_chk: assert property (@(posedge clk) disable iff (rst)
    hb_irq |-> (st_valid && tx_status[4] && $past(hb_irq_en)));

  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    hb_irq |=> !hb_irq);

  // R5
  carr_vs_late_chk: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> !(tx_status[1] && tx_status[3]));
endmodule

bind tx_fault_ctrl tx_fault_ctrl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .hb_irq_en    (hb_irq_en),
  .force_bad_crc(force_bad_crc),
  .flush_req    (flush_req),
  .st_valid     (st_valid),
  .st_ready     (st_ready),
  .tx_status    (tx_status),
  .next_frame   (next_frame),
  .hb_irq       (hb_irq)
);

// File: tb/tx_fault_ctrl_test.sv
`timescale 1ns/1ps
module tx_fault_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frm_start = 0, frm_end = 0, fifo_underrun = 0, carrier_sense = 1;
  logic collision = 0, retry_limit = 0, buf_done = 0, buf_last = 0;
  logic full_duplex = 0, hb_chk_en = 0, hb_irq_en = 0, st_ready = 1;
  logic force_bad_crc, flush_req, st_valid, next_frame, hb_irq;
  logic [4:0] tx_status;

  int n_checks = 0;
  int n_fail   = 0;
  logic [5:0] exp_q[$];
  string      tag_q[$];
  bit         nf_due = 0;
  bit         done   = 0;

  always #2 clk = ~clk;

  tx_fault_ctrl uut (
    .clk(clk), .rst(rst), .frm_start(frm_start), .frm_end(frm_end),
    .fifo_underrun(fifo_underrun), .carrier_sense(carrier_sense),
    .collision(collision), .retry_limit(retry_limit), .buf_done(buf_done),
    .buf_last(buf_last), .full_duplex(full_duplex), .hb_chk_en(hb_chk_en),
    .hb_irq_en(hb_irq_en), .force_bad_crc(force_bad_crc), .flush_req(flush_req),
    .st_valid(st_valid), .st_ready(st_ready), .tx_status(tx_status),
    .next_frame(next_frame), .hb_irq(hb_irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_status(string tag, logic irq, logic [4:0] st);
    exp_q.push_back({irq, st});
    tag_q.push_back(tag);
  endtask

  task automatic pulse_start();
    frm_start = 1; tick(1); frm_start = 0;
  endtask

  task automatic end_frame();
    frm_end = 1; tick(1); frm_end = 0;
  endtask

  task automatic close_last();
    buf_done = 1; buf_last = 1; tick(1); buf_done = 0; buf_last = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) tick(1);
    tick(2);
  endtask

  // scoreboard monitor: sampled mid-cycle, after the falling-edge drives
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (nf_due) begin
        check("R11 next_frame after handshake", next_frame, 1);
        nf_due = 0;
      end else if (next_frame) begin
        check("R11 stray next_frame", next_frame, 0);
      end
      if (st_valid && st_ready) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected status", {hb_irq, tx_status}, 0);
        end else begin
          logic [5:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, {hb_irq, tx_status}, e);
        end
        nf_due = 1;
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    // R12
    check("R12 reset outputs",
          {force_bad_crc, flush_req, st_valid, next_frame, hb_irq}, 0);

    // clean frame, no checking: R7 one-cycle latency
    pulse_start(); tick(20);
    expect_status("R7 clean frame", 0, 5'b00000);
    end_frame();
    check("R7 valid one cycle after end", st_valid, 1);
    drain();

    // R5 carrier loss, half duplex
    pulse_start(); tick(5);
    carrier_sense = 0; tick(3); carrier_sense = 1; tick(5);
    check("R5 no abort on carrier loss", flush_req, 0);
    expect_status("R5 carrier lost", 0, 5'b00010);
    end_frame(); drain();

    // R6 full duplex suppresses carrier flag
    full_duplex = 1;
    pulse_start(); tick(5);
    carrier_sense = 0; tick(6); carrier_sense = 1; tick(2);
    expect_status("R6 full duplex", 0, 5'b00000);
    end_frame(); drain();
    full_duplex = 0;

    // R4 early collision plus carrier loss: no abort, no carrier flag
    pulse_start(); tick(5);
    carrier_sense = 0; tick(4); collision = 1; tick(1); collision = 0;
    carrier_sense = 1; tick(3);
    check("R4 early collision no flush", flush_req, 0);
    expect_status("R5 collision hides carrier loss", 0, 5'b00000);
    end_frame(); drain();

    // R1/R10 underrun with carrier loss
    pulse_start(); tick(3);
    carrier_sense = 0; tick(1); carrier_sense = 1;
    fifo_underrun = 1; tick(1); fifo_underrun = 0;
    begin
      int n = 0;
      while (force_bad_crc && n < 100) begin n++; tick(1); end
      check("R1 corrupt-CRC cycles", n, 8);
    end
    check("R1 flush after corrupt phase", flush_req, 1);
    buf_done = 1; tick(1); buf_done = 0; tick(2);
    check("R2 flush held until last buffer", {flush_req, st_valid}, 2'b10);
    expect_status("R10 underrun plus carrier", 0, 5'b00011);
    close_last();
    check("R2 valid after last buffer", st_valid, 1);
    drain();

    // R3 retry limit: immediate flush
    pulse_start(); tick(4);
    retry_limit = 1; tick(1); retry_limit = 0;
    check("R3 immediate flush", {force_bad_crc, flush_req}, 2'b01);
    tick(2);
    expect_status("R3 retry limit", 0, 5'b00100);
    close_last(); drain();

    // R4 late collision
    pulse_start(); tick(140);
    collision = 1; tick(1); collision = 0;
    check("R4 late collision flush", flush_req, 1);
    expect_status("R4 late collision", 0, 5'b01000);
    close_last(); drain();

    // R7 heartbeat seen
    hb_chk_en = 1; hb_irq_en = 1;
    pulse_start(); tick(10);
    end_frame(); tick(4);
    check("R7 waiting in window", st_valid, 0);
    expect_status("R7 heartbeat present", 0, 5'b00000);
    collision = 1; tick(1); collision = 0;
    check("R7 report on heartbeat", st_valid, 1);
    drain();

    // R7/R8 heartbeat missing, interrupt enabled
    pulse_start(); tick(10);
    end_frame(); tick(19);
    check("R7 not valid before window ends", st_valid, 0);
    expect_status("R8 heartbeat missing irq", 1, 5'b10000);
    tick(1);
    check("R8 irq with first valid", {st_valid, hb_irq}, 2'b11);
    drain();

    // R8 interrupt disabled
    hb_irq_en = 0;
    pulse_start(); tick(10);
    expect_status("R8 heartbeat missing no irq", 0, 5'b10000);
    end_frame(); drain();

    // R9 aborted frame skips the window
    pulse_start(); tick(6);
    retry_limit = 1; tick(1); retry_limit = 0; tick(1);
    expect_status("R9 abort without window", 0, 5'b00100);
    close_last();
    check("R9 valid right after close", st_valid, 1);
    drain();
    hb_chk_en = 0;

    // R11 held-off handshake
    st_ready = 0;
    pulse_start(); tick(4);
    carrier_sense = 0; tick(2); carrier_sense = 1; tick(3);
    end_frame(); tick(3);
    check("R11 status held", {st_valid, tx_status}, 6'b100010);
    check("R11 no advance while held", next_frame, 0);
    expect_status("R11 released status", 0, 5'b00010);
    st_ready = 1;
    drain();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule